// File: doc/BRIEF.md
# Pulse Peak Capture Control Sequencer

This block sequences the digital side of a pulse-height analyser front end. Two comparator outputs arrive asynchronously. One says the shaped signal is above a noise threshold. The other says the input has turned down below the value held on the peak-hold node. When a peak above threshold completes, the sequencer raises an inhibit that isolates the hold node. It also raises an interrupt so the host can start its conversion.

The host acknowledges the interrupt, which clears it. The held value must stay valid for an acquisition window counted from the capture. After that window, and only once the signal has returned below the threshold, the sequencer drives a discharge pulse of fixed length. It then re-arms. The host never times the discharge pulse. The baseline check keeps the block from re-arming in the middle of a pulse.

Peak-over rising edges that arrive while the block is busy are counted as rejected pulses, giving a pile-up statistic. This counter saturates at its maximum value.

Top module: `peak_capture_seq`

## Requirements
- R1: A rising edge of the peak-over input while armed and with the threshold input high raises `irq_o` exactly 3 clock edges after the input changes: two synchroniser stages plus the state register. All outputs are active-high.
- R2: A peak-over rising edge while the threshold input is low never causes a capture and does not change the rejected-pulse count.
- R3: `inhibit_o` is high from the capture until the discharge pulse ends, and low while armed.
- R4: `irq_o` stays high until `host_ack_i` is seen high on a clock edge, and is low after that edge.
- R5: `host_ack_i` has no effect while the block is armed.
- R6: `discharge_o` rises on the first edge at which three things all hold: the acknowledge has been taken, `ACQ_CYCLES` edges have passed since the capture edge, and the synchronised threshold is low. With the acknowledge driven `a` edges and the threshold drop `b` edges after the capture edge, this is edge max(a+2, ACQ_CYCLES+1, b+3) after capture.
- R7: `discharge_o` stays high for exactly `DIS_CYCLES` cycles. On the following edge the block is armed again.
- R8: Each peak-over rising edge while not armed adds one to `reject_cnt_o`. The count holds at 2^`CNT_W`-1.
- R9: After re-arming, a peak-over input that is still high from before does not capture. A fresh rising edge is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_above_i | input | 1 | Asynchronous threshold comparator: signal above noise reference |
| peak_fall_i | input | 1 | Asynchronous peak-over comparator: input below held peak |
| host_ack_i | input | 1 | Synchronous host acknowledge of the interrupt |
| inhibit_o | output | 1 | Isolates the hold node while a peak is held |
| irq_o | output | 1 | Level-held capture interrupt |
| discharge_o | output | 1 | Hold-capacitor discharge pulse |
| reject_cnt_o | output | CNT_W | Saturating count of rejected peak-over edges |

## Verification
The main sequence is swept over every combination of acknowledge delay and baseline-return delay around the acquisition window. Each combination separates the three gating conditions, because a different one of them is the last to be met. Sub-threshold peak edges and acknowledges given while armed show that activity outside the capture state leaves the outputs unchanged. Repeated peak edges during a capture show how the rejected count grows and then saturates. A peak-over level held across re-arming shows that capture is triggered by an edge and not by a level.

// File: rtl/pcs_pkg.sv
// Shared types for the pulse peak capture sequencer.
package pcs_pkg;
    typedef enum logic [1:0] {
        ST_ARMED     = 2'd0,
        ST_CAPTURED  = 2'd1,
        ST_WAIT_BASE = 2'd2,
        ST_DISCHARGE = 2'd3
    } pcs_state_e;
endpackage

// File: rtl/pcs_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous single-bit inputs.
// Assumes each bit is a level that is stable for longer than STAGES cycles.
module pcs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift one synchroniser stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[s] <= '0;
                else if (s == 0) chain_q[s] <= async_i;
                else chain_q[s] <= chain_q[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pcs_rise_det.sv
// Rising-edge detector on a synchronised level. Assumes the input is already
// in the clk domain.
module pcs_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);
    logic prev_q;

    // Remember the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/pcs_fsm.sv
// Capture state machine: arms, captures a peak, holds it for the acquisition
// window, waits for the host and baseline, then discharges for DIS_CYCLES.
// Assumes thr_i and pk_rise_i are synchronous and host_ack_i is synchronous.
module pcs_fsm
    import pcs_pkg::*;
#(
    parameter int ACQ_CYCLES = 250,
    parameter int DIS_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       thr_i,
    input  logic       pk_rise_i,
    input  logic       host_ack_i,
    output pcs_state_e state_o,
    output logic       inhibit_o,
    output logic       irq_o,
    output logic       discharge_o
);
    localparam int ACQ_W = $clog2(ACQ_CYCLES + 1);
    localparam int DIS_W = $clog2(DIS_CYCLES + 1);

    pcs_state_e       state_q, state_d;
    logic [ACQ_W-1:0] acq_cnt_q;
    logic [DIS_W-1:0] dis_cnt_q;
    logic             capture;
    logic             acq_done;
    logic             dis_last;

    assign capture  = (state_q == ST_ARMED) && pk_rise_i && thr_i;
    assign acq_done = (acq_cnt_q == '0);
    assign dis_last = (dis_cnt_q == '0);

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED:     if (capture) state_d = ST_CAPTURED;
            ST_CAPTURED:  if (host_ack_i) state_d = ST_WAIT_BASE;
            ST_WAIT_BASE: if (acq_done && !thr_i) state_d = ST_DISCHARGE;
            ST_DISCHARGE: if (dis_last) state_d = ST_ARMED;
            default:      state_d = ST_ARMED;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARMED;
        else state_q <= state_d;
    end

    // Acquisition window timer, loaded on capture and run down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) acq_cnt_q <= '0;
        else if (capture) acq_cnt_q <= ACQ_W'(ACQ_CYCLES);
        else if (!acq_done) acq_cnt_q <= acq_cnt_q - 1'b1;
    end

    // Discharge length timer, loaded on entry to discharge.
    always_ff @(posedge clk) begin
        if (!rst_n) dis_cnt_q <= '0;
        else if (state_q == ST_WAIT_BASE && state_d == ST_DISCHARGE)
            dis_cnt_q <= DIS_W'(DIS_CYCLES - 1);
        else if (state_q == ST_DISCHARGE && !dis_last)
            dis_cnt_q <= dis_cnt_q - 1'b1;
    end

    assign state_o     = state_q;
    assign inhibit_o   = (state_q != ST_ARMED);
    assign irq_o       = (state_q == ST_CAPTURED);
    assign discharge_o = (state_q == ST_DISCHARGE);

    // R1/R2: an interrupt starts only from an armed, above-threshold edge.
    a_r1_capture_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(pk_rise_i && thr_i && !inhibit_o));
    // R4: interrupt held until acknowledged.
    a_r4_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !host_ack_i |=> irq_o);
    // R4: interrupt cleared by acknowledge.
    a_r4_irq_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && host_ack_i |=> !irq_o);
    // R3: inhibit can only end through the discharge pulse.
    a_r3_inhibit_held: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_o && !discharge_o |=> inhibit_o);
    // R6: discharge starts only at baseline after the acquisition window.
    a_r6_discharge_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(discharge_o) |-> $past(!thr_i) && $past(acq_done));
    // R7: end of discharge re-arms.
    a_r7_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(discharge_o) |-> !inhibit_o);
endmodule

// File: rtl/pcs_reject_cnt.sv
// Saturating counter of peak-over edges refused while the sequencer is busy.
// Assumes inc_i is a single-cycle pulse per event.
module pcs_reject_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // Count up on each event, holding at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R8: saturation holds.
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q == CNT_MAX |=> cnt_q == CNT_MAX);
    // R8: no change without an event.
    a_r8_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/peak_capture_seq.sv
// Top of the pulse peak capture sequencer: synchronises the two comparator
// inputs, detects peak-over edges, runs the capture state machine and counts
// rejected pulses. Assumes comparator inputs are asynchronous levels and the
// host acknowledge is synchronous to clk.
module peak_capture_seq
    import pcs_pkg::*;
#(
    parameter int ACQ_CYCLES  = 250,
    parameter int DIS_CYCLES  = 8,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thr_above_i,
    input  logic             peak_fall_i,
    input  logic             host_ack_i,
    output logic             inhibit_o,
    output logic             irq_o,
    output logic             discharge_o,
    output logic [CNT_W-1:0] reject_cnt_o
);
    logic [1:0] sync_bits;
    logic       thr_s;
    logic       pk_s;
    logic       pk_rise;
    pcs_state_e state;

    pcs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({peak_fall_i, thr_above_i}),
        .sync_o  (sync_bits)
    );
    assign thr_s = sync_bits[0];
    assign pk_s  = sync_bits[1];

    pcs_rise_det u_rise (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (pk_s),
        .rise_o  (pk_rise)
    );

    pcs_fsm #(.ACQ_CYCLES(ACQ_CYCLES), .DIS_CYCLES(DIS_CYCLES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .thr_i       (thr_s),
        .pk_rise_i   (pk_rise),
        .host_ack_i  (host_ack_i),
        .state_o     (state),
        .inhibit_o   (inhibit_o),
        .irq_o       (irq_o),
        .discharge_o (discharge_o)
    );

    pcs_reject_cnt #(.CNT_W(CNT_W)) u_rej (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (pk_rise && (state != ST_ARMED)),
        .cnt_o (reject_cnt_o)
    );
endmodule

// File: tb/peak_capture_seq_bench.sv
module peak_capture_seq_bench;
    localparam int ACQ = 6;
    localparam int DIS = 3;
    localparam int CW  = 3;
    localparam int MAXC = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic thr = 1'b0, pk = 1'b0, ack = 1'b0;
    logic inh, irq, disc;
    logic [CW-1:0] rej;

    int checks = 0;
    int fails = 0;
    int exp_rej = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    peak_capture_seq #(.ACQ_CYCLES(ACQ), .DIS_CYCLES(DIS), .CNT_W(CW)) u_peak_capture_seq (
        .clk(clk), .rst_n(rst_n), .thr_above_i(thr), .peak_fall_i(pk),
        .host_ack_i(ack), .inhibit_o(inh), .irq_o(irq), .discharge_o(disc),
        .reject_cnt_o(rej)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int max3(input int x, input int y, input int z);
        int m = x;
        if (y > m) m = y;
        if (z > m) m = z;
        return m;
    endfunction

    // Capture then sweep: ack after a edges, threshold drop after b edges.
    task automatic run_trial(input int a, input int b);
        int k;
        thr = 1'b1; pk = 1'b0; ack = 1'b0; tick(4);
        pk = 1'b1; tick(2);
        chk("R1 early", int'(irq), 0);
        tick(1);
        chk("R1 capture", int'(irq), 1);
        chk("R3 inhibit on capture", int'(inh), 1);
        pk = 1'b0;
        k = max3(a + 2, ACQ + 1, b + 3);
        for (int n = 1; n <= k + DIS + 1; n++) begin
            ack = (n - 1 == a);
            if (n - 1 == b) thr = 1'b0;
            tick(1);
            chk("R4 irq", int'(irq), int'(n <= a));
            chk("R6/R7 discharge", int'(disc), int'(n >= k && n < k + DIS));
            chk("R3 inhibit", int'(inh), int'(n < k + DIS));
        end
        ack = 1'b0;
        chk("R8 no rejects in trial", int'(rej), exp_rej);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        chk("reset inhibit", int'(inh), 0);
        chk("reset irq", int'(irq), 0);
        chk("reset discharge", int'(disc), 0);
        chk("reset count", int'(rej), 0);
        rst_n = 1'b1;
        tick(2);

        // R2: sub-threshold peak edge.
        thr = 1'b0; pk = 1'b1; tick(6);
        chk("R2 no capture irq", int'(irq), 0);
        chk("R2 no inhibit", int'(inh), 0);
        chk("R2 count unchanged", int'(rej), 0);
        pk = 1'b0; tick(4);

        // R5: acknowledge while armed.
        ack = 1'b1; tick(1); ack = 1'b0; tick(3);
        chk("R5 irq", int'(irq), 0);
        chk("R5 inhibit", int'(inh), 0);
        chk("R5 discharge", int'(disc), 0);

        // R6/R7/R4/R3: sweep acknowledge and baseline delays.
        for (int a = 0; a <= ACQ + 2; a++)
            for (int b = 0; b <= ACQ + 3; b++)
                run_trial(a, b);

        // R8: rejected edges during a capture, through saturation.
        thr = 1'b1; pk = 1'b0; tick(4);
        pk = 1'b1; tick(3);
        chk("R1 capture before pile-up", int'(irq), 1);
        for (int i = 0; i < MAXC + 2; i++) begin
            pk = 1'b0; tick(3);
            pk = 1'b1; tick(4);
            exp_rej = (exp_rej < MAXC) ? exp_rej + 1 : MAXC;
            chk("R8 reject count", int'(rej), exp_rej);
            chk("R4 irq held during pile-up", int'(irq), 1);
        end

        // R9: peak-over level held across re-arm.
        ack = 1'b1; tick(1); ack = 1'b0;
        thr = 1'b0; tick(ACQ + DIS + 6);
        chk("R7 rearmed", int'(inh), 0);
        thr = 1'b1; tick(6);
        chk("R9 held level no capture", int'(irq), 0);
        chk("R9 held level no inhibit", int'(inh), 0);
        pk = 1'b0; tick(4);
        pk = 1'b1; tick(3);
        chk("R9 fresh edge captures", int'(irq), 1);
        chk("R8 count saturated", int'(rej), MAXC);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule